// File: doc/BRIEF.md
# Segmented Bank Address Translator

This block sits between an 8-bit processor with a 16-bit address bus and a 4 MB physical memory. The physical space is treated as 256 banks of 16 KB each. The top two logical address bits pick one of four 16 KB windows, and each window holds a bank number in a small register that the processor loads with I/O-port writes. The translated 22-bit address is formed combinationally, so it adds no cycle to a memory access.

Window 0 is treated differently. Its lower 8 KB can never be redirected by a register. It is tied either to bank 0x00, the boot ROM selected after reset, or to bank 0x20, the system RAM used once the machine is running. A single control bit chooses between the two.

Its upper 8 KB maps one 8 KB half of an even-numbered bank. Register bits 7..1 name the bank, and register bit 0 picks the half. The stored bank values are driven on a readback bus so that they can be inspected.

Top module: `bank_xlat`

## Requirements
- R1: After reset every window register holds 0 and the control bit selects ROM, so `bank_regs` reads 0 and logical 0x0000 translates to physical 0x000000.
- R2: When `io_wr` is high at a rising clock edge, `io_data` is stored in the register named by `io_sel`. The value appears on `bank_regs[8*io_sel +: 8]` after that edge, and the other registers keep their values.
- R3: For logical bits [15:14] not equal to 0, the physical address is {register[bits 15:14], logical[13:0]}.
- R4: For logical 0x0000–0x1FFF, the physical address is {B, 1'b0, logical[12:0]}. B is 0x00 when the control bit is 0 and 0x20 when it is 1. The window-0 register has no effect on this range.
- R5: When `boot_wr` is high at a rising clock edge, `io_data[0]` is loaded into the control bit. The new mapping of the lower 8 KB applies from the next cycle.
- R6: For logical 0x2000–0x3FFF, the physical address is {reg0[7:1], 1'b0, reg0[0], logical[12:0]}.
- R7: Every address in window 0 lands in an even bank, so physical bit 14 is 0 whenever logical bits [15:14] are 0.
- R8: Translation has no latency. A change on `log_addr` is reflected on `phys_addr` within the same cycle.
- R9: `io_wr` and `boot_wr` asserted in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for a window register |
| io_sel | input | 2 | Window register select |
| io_data | input | 8 | Write data; bit 0 also feeds the control bit |
| boot_wr | input | 1 | Write strobe for the ROM/RAM control bit |
| log_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 22 | Translated physical address |
| bank_regs | output | 32 | Readback of the four window registers, window 0 in the low byte |

## Verification
The bench builds the block with its default parameters: a 16-bit logical address, 2 window-select bits, 8-bit bank numbers, the split window 0 enabled, and fixed banks 0x00 and 0x20. These defaults put both lower-8 KB banks within reach, along with both halves of an even bank and both ends of every window. A reference model in the bench, built from the requirements, predicts each translated address. Stimulus sweeps window-0 register values with bit 0 set and clear, and it checks that a register write does not appear before the clock edge.

// File: rtl/bxlat_pkg.sv
package bxlat_pkg;

   // Address class inside the logical space
   typedef enum logic [1:0] {
      RG_PLAIN     = 2'd0,
      RG_SEG0_LOW  = 2'd1,
      RG_SEG0_HIGH = 2'd2
   } region_e;

endpackage

// File: rtl/bxlat_regs.sv
module bxlat_regs #(
   parameter int SEG_W  = 2,
   parameter int BANK_W = 8,
   localparam int NSEG  = 1 << SEG_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SEG_W-1:0]                 wr_sel,
   input  logic [BANK_W-1:0]                wr_data,
   output logic [NSEG-1:0][BANK_W-1:0]      bank_q
);

   generate
      if (SEG_W < 1) begin : g_bad_seg
         $error("bxlat_regs: SEG_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (wr_en) begin
         bank_q[wr_sel] <= wr_data;
      end
   end

   // R2
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bank_q[$past(wr_sel)] == $past(wr_data));

   // R2
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_q));

endmodule

// File: rtl/bxlat_bootctl.sv
module bxlat_bootctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic use_ram
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_ram <= 1'b0;
      end else if (wr_en) begin
         use_ram <= wr_bit;
      end
   end

   // R5
   boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> use_ram == $past(wr_bit));

   // R5
   boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(use_ram));

endmodule

// File: rtl/bxlat_map.sv
module bxlat_map
   import bxlat_pkg::*;
#(
   parameter int          LOG_W      = 16,
   parameter int          SEG_W      = 2,
   parameter int          BANK_W     = 8,
   parameter bit          SEG0_SPLIT = 1'b1,
   parameter logic [BANK_W-1:0] ROM_BANK = 8'h00,
   parameter logic [BANK_W-1:0] RAM_BANK = 8'h20,
   localparam int NSEG   = 1 << SEG_W,
   localparam int OFF_W  = LOG_W - SEG_W,
   localparam int HALF_W = OFF_W - 1,
   localparam int PHYS_W = BANK_W + OFF_W
) (
   input  logic [LOG_W-1:0]              log_addr,
   input  logic [NSEG-1:0][BANK_W-1:0]   bank_regs,
   input  logic                          use_ram,
   output logic [PHYS_W-1:0]             phys_addr
);

   logic [SEG_W-1:0] seg;
   logic [OFF_W-1:0] off;

   assign seg = log_addr[LOG_W-1:OFF_W];
   assign off = log_addr[OFF_W-1:0];

   generate
      if (OFF_W < 2) begin : g_bad_off
         $error("bxlat_map: LOG_W must exceed SEG_W by at least 2");
      end

      if (SEG0_SPLIT) begin : g_split
         region_e          region;
         logic [BANK_W-1:0] fixed_bank;

         assign fixed_bank = use_ram ? RAM_BANK : ROM_BANK;

         always_comb begin
            if (seg != '0)            region = RG_PLAIN;
            else if (off[HALF_W])     region = RG_SEG0_HIGH;
            else                      region = RG_SEG0_LOW;
         end

         always_comb begin
            case (region)
               RG_SEG0_LOW:
                  phys_addr = {fixed_bank, 1'b0, off[HALF_W-1:0]};
               RG_SEG0_HIGH:
                  phys_addr = {bank_regs[0][BANK_W-1:1], 1'b0,
                               bank_regs[0][0], off[HALF_W-1:0]};
               default:
                  phys_addr = {bank_regs[seg], off};
            endcase
         end
      end else begin : g_flat
         assign phys_addr = {bank_regs[seg], off};
      end
   endgenerate

endmodule

// File: rtl/bank_xlat.sv
module bank_xlat #(
   parameter int          LOG_W      = 16,
   parameter int          SEG_W      = 2,
   parameter int          BANK_W     = 8,
   parameter bit          SEG0_SPLIT = 1'b1,
   parameter logic [BANK_W-1:0] ROM_BANK = 8'h00,
   parameter logic [BANK_W-1:0] RAM_BANK = 8'h20,
   localparam int NSEG   = 1 << SEG_W,
   localparam int OFF_W  = LOG_W - SEG_W,
   localparam int PHYS_W = BANK_W + OFF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     io_wr,
   input  logic [SEG_W-1:0]         io_sel,
   input  logic [BANK_W-1:0]        io_data,
   input  logic                     boot_wr,
   input  logic [LOG_W-1:0]         log_addr,
   output logic [PHYS_W-1:0]        phys_addr,
   output logic [NSEG*BANK_W-1:0]   bank_regs
);

   logic [NSEG-1:0][BANK_W-1:0] bank_q;
   logic                        use_ram;

   bxlat_regs #(.SEG_W(SEG_W), .BANK_W(BANK_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (io_wr),
      .wr_sel (io_sel),
      .wr_data(io_data),
      .bank_q (bank_q)
   );

   bxlat_bootctl u_boot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (boot_wr),
      .wr_bit (io_data[0]),
      .use_ram(use_ram)
   );

   bxlat_map #(
      .LOG_W(LOG_W), .SEG_W(SEG_W), .BANK_W(BANK_W),
      .SEG0_SPLIT(SEG0_SPLIT), .ROM_BANK(ROM_BANK), .RAM_BANK(RAM_BANK)
   ) u_map (
      .log_addr (log_addr),
      .bank_regs(bank_q),
      .use_ram  (use_ram),
      .phys_addr(phys_addr)
   );

   assign bank_regs = bank_q;

   // R3
   plain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_addr[LOG_W-1:OFF_W] != '0) |->
         (phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]
          && phys_addr[PHYS_W-1:OFF_W] == bank_q[log_addr[LOG_W-1:OFF_W]]));

   generate
      if (SEG0_SPLIT) begin : g_seg0_chk
         // R7
         even_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (log_addr[LOG_W-1:OFF_W] == '0) |-> (phys_addr[OFF_W] == 1'b0));

         // R4
         low_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (log_addr[LOG_W-1:OFF_W-1] == '0) |->
               (phys_addr[PHYS_W-1:OFF_W] == (use_ram ? RAM_BANK : ROM_BANK)));
      end
   endgenerate

endmodule

// File: tb/tb_bank_xlat.sv
`timescale 1ns/1ps
module tb_bank_xlat;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [1:0]  io_sel = '0;
   logic [7:0]  io_data = '0;
   logic        boot_wr = 1'b0;
   logic [15:0] log_addr = '0;
   logic [21:0] phys_addr;
   logic [31:0] bank_regs;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_bank [4];
   logic       m_boot;

   always #2 clk = ~clk;

   bank_xlat dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
      .io_data(io_data), .boot_wr(boot_wr), .log_addr(log_addr),
      .phys_addr(phys_addr), .bank_regs(bank_regs)
   );

   function automatic logic [21:0] model(input logic [15:0] a);
      if (a[15:14] != 2'd0) return {m_bank[a[15:14]], a[13:0]};
      if (!a[13]) return {(m_boot ? 8'h20 : 8'h00), 1'b0, a[12:0]};
      return {m_bank[0][7:1], 1'b0, m_bank[0][0], a[12:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xl(input string req, input logic [15:0] a);
      log_addr = a;
      #0.5;
      chk(req, {10'd0, phys_addr}, {10'd0, model(a)});
   endtask

   task automatic regs_chk(input string req);
      chk(req, bank_regs, {m_bank[3], m_bank[2], m_bank[1], m_bank[0]});
   endtask

   task automatic wr_seg(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_sel = s; io_data = d;
      @(posedge clk); #1;
      io_wr = 1'b0;
      m_bank[s] = d;
   endtask

   task automatic wr_boot(input logic b);
      @(negedge clk);
      boot_wr = 1'b1; io_data = {7'd0, b};
      @(posedge clk); #1;
      boot_wr = 1'b0;
      m_boot = b;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) m_bank[i] = '0;
      m_boot = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      regs_chk("R1 regs");
      xl("R1 addr0", 16'h0000);
   endtask

   task automatic t_write;
      wr_seg(2'd1, 8'h41);
      regs_chk("R2 seg1");
      wr_seg(2'd2, 8'h9C);
      wr_seg(2'd3, 8'hFF);
      wr_seg(2'd0, 8'h35);
      regs_chk("R2 all");
      // write visible only after the edge
      @(negedge clk);
      io_wr = 1'b1; io_sel = 2'd2; io_data = 8'h77;
      #0.5 regs_chk("R2 pre-edge");
      @(posedge clk); #1;
      io_wr = 1'b0; m_bank[2] = 8'h77;
      regs_chk("R2 post-edge");
   endtask

   task automatic t_plain;
      xl("R3 s1 lo", 16'h4000);
      xl("R3 s1 hi", 16'h7FFF);
      xl("R3 s2", 16'h9234);
      xl("R3 s3 top", 16'hFFFF);
      xl("R3 s3 lo", 16'hC001);
   endtask

   task automatic t_low;
      xl("R4 rom lo", 16'h0000);
      xl("R4 rom hi", 16'h1FFF);
      wr_seg(2'd0, 8'hFF);
      xl("R4 reg0 ignored", 16'h1234);
   endtask

   task automatic t_boot;
      @(negedge clk);
      boot_wr = 1'b1; io_data = 8'h01;
      log_addr = 16'h0ABC;
      #0.5 chk("R5 before edge", {10'd0, phys_addr}, {10'd0, model(16'h0ABC)});
      @(posedge clk); #1;
      boot_wr = 1'b0; m_boot = 1'b1;
      xl("R5 ram", 16'h0ABC);
      xl("R5 ram top", 16'h1FFF);
   endtask

   task automatic t_high;
      wr_seg(2'd0, 8'h35);
      xl("R6 odd half", 16'h2ABC);
      xl("R7 odd reg", 16'h3FFF);
      wr_seg(2'd0, 8'h34);
      xl("R6 even half", 16'h2000);
      wr_seg(2'd0, 8'hFF);
      xl("R6 top", 16'h3FFF);
      chk("R7 bit14", {31'd0, phys_addr[14]}, 32'd0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      log_addr = 16'h5555;
      #0.5 chk("R8 same cycle a", {10'd0, phys_addr}, {10'd0, model(16'h5555)});
      log_addr = 16'h2001;
      #0.5 chk("R8 same cycle b", {10'd0, phys_addr}, {10'd0, model(16'h2001)});
   endtask

   task automatic t_simul;
      @(negedge clk);
      io_wr = 1'b1; io_sel = 2'd3; io_data = 8'hC6; boot_wr = 1'b1;
      @(posedge clk); #1;
      io_wr = 1'b0; boot_wr = 1'b0;
      m_bank[3] = 8'hC6; m_boot = 1'b0;
      regs_chk("R9 reg");
      xl("R9 boot", 16'h0100);
      xl("R9 map", 16'hC100);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_write();
      t_plain();
      t_low();
      t_boot();
      t_high();
      t_latency();
      wr_boot(1'b1);
      t_simul();
      finish_run();
   end

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule